// File: doc/BRIEF.md
# Event Stream Operator Unit

The unit takes in a stream of timestamped events, each carrying a stream ID, a data value and a 64-bit timestamp. Static configuration inputs assign stream IDs to operator roles. The roles are an event counter, a running sum, a latest-value holder with a default, a trigger for a time window, a filtered stream and two merged streams.

The block keeps one small aggregate per role. It presents the results as signals that hold their value between events. It also produces two derived event streams: a filtered stream and a merged stream.

Time in the unit is the timestamp carried by the events, not the clock. The window predicate compares event timestamps with the configured duration. The filter decides on each event using the state that existed before that event. An event is accepted only if its timestamp is not lower than the newest accepted timestamp. Any other event is discarded entirely.

Top module: `esou_top`

## Requirements
- R1: Each accepted event whose ID equals `cfg_cnt_id_i` raises `cnt_o` by exactly one, whatever its value. Other events leave `cnt_o` unchanged.
- R2: Each accepted event whose ID equals `cfg_sum_id_i` adds its value to `sum_o`, modulo 2^32. Other events leave `sum_o` unchanged.
- R3: `mrv_o` shows `cfg_mrv_dflt_i` until the first accepted event with ID `cfg_mrv_id_i`. After that it shows the value of the latest such event.
- R4: `win_o` is 1 exactly when a trigger event (ID `cfg_trig_id_i`) has been accepted and the newest accepted timestamp minus the latest trigger timestamp is at most `cfg_win_len_i`.
- R5: For an accepted event with ID `cfg_flt_id_i`, the condition is evaluated on the state before that event. The condition is: a trigger has been seen, the event timestamp minus the latest trigger timestamp is at most `cfg_win_len_i`, and `cnt_o` is below `cfg_cnt_lim_i`. If the condition holds, the event's value and timestamp appear on `flt_*` with `flt_valid_o` high for one cycle. Otherwise the event is dropped.
- R6: An accepted event with ID `cfg_mrg_a_id_i` or `cfg_mrg_b_id_i` appears on `mrg_*` for one cycle. `mrg_src_o` is 0 for stream A and 1 for stream B. When both IDs are equal, stream A wins and `mrg_src_o` is 0.
- R7: A new event is accepted on every clock cycle, back to back. Every output reflects an event from the clock edge that accepts it: the signals are updated and the event outputs are valid in the following cycle.
- R8: An event whose timestamp is lower than the newest accepted timestamp is ignored: it changes no aggregate and produces no output event. An equal timestamp is accepted.
- R9: After reset, `cnt_o`=0, `sum_o`=0, `mrv_o`=`cfg_mrv_dflt_i`, `win_o`=0, and both valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Input event present |
| ev_id_i | input | 8 | Input event stream ID |
| ev_val_i | input | 32 | Input event value |
| ev_ts_i | input | 64 | Input event timestamp |
| cfg_cnt_id_i | input | 8 | Stream counted |
| cfg_sum_id_i | input | 8 | Stream summed |
| cfg_mrv_id_i | input | 8 | Stream whose latest value is held |
| cfg_mrv_dflt_i | input | 32 | Value held before the first event |
| cfg_trig_id_i | input | 8 | Window trigger stream |
| cfg_win_len_i | input | 64 | Window duration in timestamp units |
| cfg_flt_id_i | input | 8 | Stream passed through the filter |
| cfg_cnt_lim_i | input | 32 | Count bound used by the filter condition |
| cfg_mrg_a_id_i | input | 8 | First merged stream (priority) |
| cfg_mrg_b_id_i | input | 8 | Second merged stream |
| cnt_o | output | 32 | Event count signal |
| sum_o | output | 32 | Sum signal |
| mrv_o | output | 32 | Latest-value signal |
| win_o | output | 1 | Window predicate |
| flt_valid_o | output | 1 | Filtered event valid |
| flt_val_o | output | 32 | Filtered event value |
| flt_ts_o | output | 64 | Filtered event timestamp |
| mrg_valid_o | output | 1 | Merged event valid |
| mrg_val_o | output | 32 | Merged event value |
| mrg_ts_o | output | 64 | Merged event timestamp |
| mrg_src_o | output | 1 | Merged event source, 0 = A, 1 = B |

## Verification
A corrupted aggregate shows at the ports one cycle after the event that updates it, because every signal output reads its register directly. A corrupted trigger timestamp or newest-timestamp register flips `win_o` at once. It also corrupts the next filter decision, which shows as a missing or extra `flt_valid_o` pulse one cycle after that filtered event. A wrong stale-timestamp guard shows one cycle after the out-of-order event, as a moved aggregate or a spurious output pulse.

// File: rtl/esou_pkg.sv
package esou_pkg;
  parameter int ID_W  = 8;
  parameter int VAL_W = 32;
  parameter int TS_W  = 64;
  parameter int CNT_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [VAL_W-1:0] val;
    logic [TS_W-1:0]  ts;
  } ev_t;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } mrg_src_e;
endpackage

// File: rtl/esou_agg.sv
// Aggregate register: accumulating (count/sum) or latest-value holding.
module esou_agg #(
  parameter bit ACCUM = 1'b1,
  parameter int W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] dflt_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         seen_q;

  generate
    if (ACCUM) begin : g_accum
      assign acc_d = acc_q + val_i;
    end else begin : g_latest
      assign acc_d = val_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (hit_i) begin
      acc_q  <= acc_d;
      seen_q <= 1'b1;
    end
  end

  assign res_o = seen_q ? acc_q : dflt_i;

  // R1 R2 R3
  agg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(acc_q) && $stable(seen_q));

  // R3
  agg_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> seen_q);
endmodule

// File: rtl/esou_window.sv
// Past-time window driven by event timestamps.
module esou_window #(
  parameter int TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_hit_i,
  input  logic [TS_W-1:0] ev_ts_i,
  input  logic [TS_W-1:0] now_ts_i,
  input  logic [TS_W-1:0] win_len_i,
  output logic            win_o,
  output logic            ev_in_win_o
);
  logic [TS_W-1:0] trig_ts_q;
  logic            trig_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_ts_q   <= '0;
      trig_seen_q <= 1'b0;
    end else if (trig_hit_i) begin
      trig_ts_q   <= ev_ts_i;
      trig_seen_q <= 1'b1;
    end
  end

  // timestamps never run backwards once accepted, so differences do not wrap
  assign win_o       = trig_seen_q && ((now_ts_i - trig_ts_q) <= win_len_i);
  assign ev_in_win_o = trig_seen_q && ((ev_ts_i  - trig_ts_q) <= win_len_i);

  // R4
  trig_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit_i |=> win_o);

  // R4
  win_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_o |-> trig_seen_q);
endmodule

// File: rtl/esou_route.sv
// Output event registers for the filter and merge streams.
module esou_route
  import esou_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     acc_i,
  input  ev_t      ev_i,
  input  logic     is_flt_i,
  input  logic     cond_i,
  input  logic     is_a_i,
  input  logic     is_b_i,
  output logic     flt_valid_o,
  output ev_t      flt_ev_o,
  output logic     mrg_valid_o,
  output ev_t      mrg_ev_o,
  output mrg_src_e mrg_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_valid_o <= 1'b0;
      mrg_valid_o <= 1'b0;
      flt_ev_o    <= '0;
      mrg_ev_o    <= '0;
      mrg_src_o   <= SRC_A;
    end else begin
      flt_valid_o <= acc_i && is_flt_i && cond_i;
      mrg_valid_o <= acc_i && (is_a_i || is_b_i);
      if (acc_i && is_flt_i) flt_ev_o <= ev_i;
      if (acc_i && (is_a_i || is_b_i)) begin
        mrg_ev_o  <= ev_i;
        mrg_src_o <= is_a_i ? SRC_A : SRC_B; // A has priority
      end
    end
  end

  // R6
  mrg_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && is_a_i |=> mrg_valid_o && (mrg_src_o == SRC_A));

  // R5
  flt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && is_flt_i) |=> !flt_valid_o);
endmodule

// File: rtl/esou_top.sv
module esou_top
  import esou_pkg::*;
#(
  parameter int ID_W_P  = ID_W,
  parameter int VAL_W_P = VAL_W,
  parameter int TS_W_P  = TS_W,
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_valid_i,
  input  logic [ID_W_P-1:0]  ev_id_i,
  input  logic [VAL_W_P-1:0] ev_val_i,
  input  logic [TS_W_P-1:0]  ev_ts_i,
  input  logic [ID_W_P-1:0]  cfg_cnt_id_i,
  input  logic [ID_W_P-1:0]  cfg_sum_id_i,
  input  logic [ID_W_P-1:0]  cfg_mrv_id_i,
  input  logic [VAL_W_P-1:0] cfg_mrv_dflt_i,
  input  logic [ID_W_P-1:0]  cfg_trig_id_i,
  input  logic [TS_W_P-1:0]  cfg_win_len_i,
  input  logic [ID_W_P-1:0]  cfg_flt_id_i,
  input  logic [CNT_W_P-1:0] cfg_cnt_lim_i,
  input  logic [ID_W_P-1:0]  cfg_mrg_a_id_i,
  input  logic [ID_W_P-1:0]  cfg_mrg_b_id_i,
  output logic [CNT_W_P-1:0] cnt_o,
  output logic [VAL_W_P-1:0] sum_o,
  output logic [VAL_W_P-1:0] mrv_o,
  output logic               win_o,
  output logic               flt_valid_o,
  output logic [VAL_W_P-1:0] flt_val_o,
  output logic [TS_W_P-1:0]  flt_ts_o,
  output logic               mrg_valid_o,
  output logic [VAL_W_P-1:0] mrg_val_o,
  output logic [TS_W_P-1:0]  mrg_ts_o,
  output logic               mrg_src_o
);
  localparam logic [CNT_W_P-1:0] CNT_ONE = CNT_W_P'(1);

  logic [TS_W_P-1:0] last_ts_q;
  logic              acc, ev_in_win, flt_cond;
  ev_t               ev, flt_ev, mrg_ev;
  mrg_src_e          src;

  // R8: stale timestamps are rejected, equal ones accepted
  assign acc = ev_valid_i && (ev_ts_i >= last_ts_q);
  assign ev  = '{id: ev_id_i, val: ev_val_i, ts: ev_ts_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_ts_q <= '0;
    else if (acc) last_ts_q <= ev_ts_i;
  end

  esou_agg #(.ACCUM(1'b1), .W(CNT_W_P)) u_cnt (
    .clk_i, .rst_ni,
    .hit_i (acc && (ev_id_i == cfg_cnt_id_i)),
    .val_i (CNT_ONE),
    .dflt_i('0),
    .res_o (cnt_o)
  );

  esou_agg #(.ACCUM(1'b1), .W(VAL_W_P)) u_sum (
    .clk_i, .rst_ni,
    .hit_i (acc && (ev_id_i == cfg_sum_id_i)),
    .val_i (ev_val_i),
    .dflt_i('0),
    .res_o (sum_o)
  );

  esou_agg #(.ACCUM(1'b0), .W(VAL_W_P)) u_mrv (
    .clk_i, .rst_ni,
    .hit_i (acc && (ev_id_i == cfg_mrv_id_i)),
    .val_i (ev_val_i),
    .dflt_i(cfg_mrv_dflt_i),
    .res_o (mrv_o)
  );

  esou_window #(.TS_W(TS_W_P)) u_win (
    .clk_i, .rst_ni,
    .trig_hit_i (acc && (ev_id_i == cfg_trig_id_i)),
    .ev_ts_i,
    .now_ts_i   (last_ts_q),
    .win_len_i  (cfg_win_len_i),
    .win_o,
    .ev_in_win_o(ev_in_win)
  );

  // condition sampled on pre-event state
  assign flt_cond = ev_in_win && (cnt_o < cfg_cnt_lim_i);

  esou_route u_route (
    .clk_i, .rst_ni,
    .acc_i      (acc),
    .ev_i       (ev),
    .is_flt_i   (ev_id_i == cfg_flt_id_i),
    .cond_i     (flt_cond),
    .is_a_i     (ev_id_i == cfg_mrg_a_id_i),
    .is_b_i     (ev_id_i == cfg_mrg_b_id_i),
    .flt_valid_o,
    .flt_ev_o   (flt_ev),
    .mrg_valid_o,
    .mrg_ev_o   (mrg_ev),
    .mrg_src_o  (src)
  );

  assign flt_val_o = flt_ev.val;
  assign flt_ts_o  = flt_ev.ts;
  assign mrg_val_o = mrg_ev.val;
  assign mrg_ts_o  = mrg_ev.ts;
  assign mrg_src_o = src;

  // R8
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && (ev_ts_i < last_ts_q)
      |=> !flt_valid_o && !mrg_valid_o && $stable(cnt_o) && $stable(sum_o));

  // R8
  ts_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 last_ts_q >= $past(last_ts_q));

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (ev_id_i == cfg_cnt_id_i) |=> cnt_o == $past(cnt_o) + CNT_ONE);

  // R7
  mrg_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o |-> $past(ev_valid_i));
endmodule

// File: tb/esou_top_test.sv
module esou_top_test;
  typedef struct packed {
    logic [7:0]  id;
    logic [31:0] val;
    logic [63:0] ts;
    logic [31:0] cnt;
    logic [31:0] sum;
    logic [31:0] mrv;
    logic        win;
    logic        flt;
    logic        mrg;
    logic        src;
  } vec_t;

  localparam int NV = 13;
  localparam logic [31:0] DFLT = 32'hDEAD;
  // cnt=1 sum=2 mrv=3 trig=4 flt=5 win_len=10 cnt_lim=2 mrg A=2 B=3
  localparam vec_t VEC [NV] = '{
    '{8'd5, 32'd7,          64'd1,  32'd0, 32'd0,  DFLT,   1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd4, 32'd0,          64'd2,  32'd0, 32'd0,  DFLT,   1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd5, 32'd9,          64'd5,  32'd0, 32'd0,  DFLT,   1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd1, 32'd100,        64'd6,  32'd1, 32'd0,  DFLT,   1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd2, 32'd20,         64'd8,  32'd1, 32'd20, DFLT,   1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd3, 32'd33,         64'd12, 32'd1, 32'd20, 32'd33, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd5, 32'd4,          64'd13, 32'd1, 32'd20, 32'd33, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd4, 32'd0,          64'd13, 32'd1, 32'd20, 32'd33, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd1, 32'd0,          64'd14, 32'd2, 32'd20, 32'd33, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd5, 32'd6,          64'd14, 32'd2, 32'd20, 32'd33, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd2, 32'hFFFF_FFF0,  64'd20, 32'd2, 32'd4,  32'd33, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd3, 32'd1,          64'd23, 32'd2, 32'd4,  32'd1,  1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd1, 32'd55,         64'd24, 32'd3, 32'd4,  32'd1,  1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_id = '0;
  logic [31:0] ev_val = '0;
  logic [63:0] ev_ts = '0;
  logic [7:0]  mrg_b_id = 8'd3;
  logic [31:0] cnt, sum, mrv, flt_val, mrg_val;
  logic [63:0] flt_ts, mrg_ts;
  logic        win, flt_valid, mrg_valid, mrg_src;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  esou_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_id_i(ev_id), .ev_val_i(ev_val), .ev_ts_i(ev_ts),
    .cfg_cnt_id_i(8'd1), .cfg_sum_id_i(8'd2), .cfg_mrv_id_i(8'd3),
    .cfg_mrv_dflt_i(DFLT), .cfg_trig_id_i(8'd4), .cfg_win_len_i(64'd10),
    .cfg_flt_id_i(8'd5), .cfg_cnt_lim_i(32'd2),
    .cfg_mrg_a_id_i(8'd2), .cfg_mrg_b_id_i(mrg_b_id),
    .cnt_o(cnt), .sum_o(sum), .mrv_o(mrv), .win_o(win),
    .flt_valid_o(flt_valid), .flt_val_o(flt_val), .flt_ts_o(flt_ts),
    .mrg_valid_o(mrg_valid), .mrg_val_o(mrg_val), .mrg_ts_o(mrg_ts),
    .mrg_src_o(mrg_src)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] id, input logic [31:0] val, input logic [63:0] ts);
    ev_valid = 1'b1; ev_id = id; ev_val = val; ev_ts = ts;
  endtask

  task automatic check_vec(input vec_t v);
    chk("R1 cnt", 64'(cnt), 64'(v.cnt));
    chk("R2 sum", 64'(sum), 64'(v.sum));
    chk("R3 mrv", 64'(mrv), 64'(v.mrv));
    chk("R4 win", 64'(win), 64'(v.win));
    chk("R5 flt_valid", 64'(flt_valid), 64'(v.flt));
    if (v.flt) begin
      chk("R5 flt_val", 64'(flt_val), 64'(v.val));
      chk("R5 flt_ts", flt_ts, v.ts);
    end
    chk("R6 mrg_valid", 64'(mrg_valid), 64'(v.mrg));
    if (v.mrg) begin
      chk("R6 mrg_val", 64'(mrg_val), 64'(v.val));
      chk("R6 mrg_ts", mrg_ts, v.ts);
      chk("R6 mrg_src", 64'(mrg_src), 64'(v.src));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 cnt", 64'(cnt), 64'd0);
    chk("R9 sum", 64'(sum), 64'd0);
    chk("R9 mrv", 64'(mrv), 64'(DFLT));
    chk("R9 win", 64'(win), 64'd0);
    chk("R9 valids", 64'({flt_valid, mrg_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: one event per cycle, back to back, checked one cycle later
    for (int i = 0; i < NV; i++) begin
      if (i > 0) check_vec(VEC[i-1]);
      drive(VEC[i].id, VEC[i].val, VEC[i].ts);
      @(negedge clk);
    end
    check_vec(VEC[NV-1]);

    // R8: stale timestamp on merged/summed stream is ignored
    drive(8'd2, 32'd77, 64'd5);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R8 stale sum", 64'(sum), 64'd4);
    chk("R8 stale mrg", 64'(mrg_valid), 64'd0);
    chk("R8 stale cnt", 64'(cnt), 64'd3);
    // R8: stale filter event with open window yields nothing
    drive(8'd4, 32'd0, 64'd24);
    @(negedge clk);
    drive(8'd5, 32'd8, 64'd23);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R8 stale flt", 64'(flt_valid), 64'd0);
    // R8: equal timestamp accepted
    drive(8'd1, 32'd0, 64'd24);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R8 equal ts cnt", 64'(cnt), 64'd4);

    // R6: both merge IDs equal -> source A
    mrg_b_id = 8'd2;
    drive(8'd2, 32'd3, 64'd25);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R6 same id valid", 64'(mrg_valid), 64'd1);
    chk("R6 same id src", 64'(mrg_src), 64'd0);
    @(negedge clk);
    chk("R6 one cycle pulse", 64'(mrg_valid), 64'd0);
    // R7: signals hold between events
    chk("R7 hold sum", 64'(sum), 64'd7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule